// File: doc/BRIEF.md
# Prescaled Countdown Timer

A 32-bit down-counting timer attached to a simple word-addressed register bus. Software programs a reload period, a prescale value and a starting count, then switches the timer on. Once running, the count steps down by one every scale+1 clock cycles. When the count stands at zero the timer expires. It then sets a sticky flag in the control register and emits a single-cycle interrupt request. After that it either halts with the count held at zero (one-shot) or loads the count again from the period register and keeps going (auto-reload).

Counting needs two control bits, a power qualifier and an enable, both set. Writing zero to the control register turns the timer off and clears the flag. If the timer is switched on while the count already reads zero, it expires at once without waiting for the prescaler. The interrupt output goes to a single line of an external interrupt controller. The vector fetch and priority handling stay on that side.

Top module: `tick_down_timer`

## Requirements
- R1: After reset all four registers read 0 and `irq_out` is low.
- R2: Register selection uses byte address bits [3:2]: 0x0 control, 0x4 period, 0x8 scale, 0xC count. Period and scale read back the last value written, whatever the control bits are.
- R3: Control bit 0 is power, bit 1 is enable, bit 2 is auto-reload and bit 3 is the expiry flag; the upper bits read 0. The count changes only through a bus write unless bits 0 and 1 are both set.
- R4: While running with a nonzero count, the count decrements once every scale+1 cycles. The prescaler restarts on any write to scale or count, on expiry, and whenever the timer is not counting.
- R5: In one-shot mode (bit 2 clear) an expiry leaves the count at 0 and the enable bit set, so control reads 0xB. No further expiry follows until control or count is written again.
- R6: In auto-reload mode (bit 2 set) an expiry loads the count from the period value in force in the expiry cycle, and counting continues; control reads 0xF.
- R7: A write to control that leaves power and enable set while the count is 0 produces an expiry in the very next cycle, and `irq_out` is high after the following clock edge.
- R8: Each expiry drives `irq_out` high for exactly the one cycle after the expiry cycle, and the flag is already set whenever `irq_out` is high.
- R9: A control write with bit 3 clear clears the flag. A control write with bit 3 set leaves the flag at its previous value.
- R10: A write to the count register loads the written value and overrides a decrement or reload in the same cycle. A cycle carrying a write to control or count produces no expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W (4) | Byte address; bits [3:2] select the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | One-cycle expiry interrupt request |

## Verification
The assertions assume that the bus inputs carry no unknown values after reset and that a write lasts one cycle with its address and data stable across the clock edge. They also rely on control and count writes cancelling the expiry of their own cycle. This lets them tie `irq_out` to the mode bit and the count without tracking overlapping writes. The stimulus drives every input on the falling edge from a single process and holds it through the rising edge. Random values stay small (period below 16, scale below 4, count below 21), so expiries, reloads and prescaler wraps happen often within a few thousand cycles.

// File: rtl/tdt_pkg.sv
package tdt_pkg;

   typedef enum logic [1:0] {
      SEL_CTRL   = 2'd0,
      SEL_PERIOD = 2'd1,
      SEL_SCALE  = 2'd2,
      SEL_COUNT  = 2'd3
   } tdt_sel_e;

   localparam int CTRL_BITS = 4;

   typedef struct packed {
      logic flag;
      logic autold;
      logic en;
      logic pwr;
   } tdt_ctrl_t;

endpackage

// File: rtl/tdt_regs.sv
module tdt_regs
   import tdt_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic              wr_period,
   input  logic              wr_scale,
   input  logic [DATA_W-1:0] wdata,
   input  logic              expire,
   output tdt_ctrl_t         ctrl,
   output logic [DATA_W-1:0] period,
   output logic [DATA_W-1:0] scale
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl   <= '0;
         period <= '0;
         scale  <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl.pwr    <= wdata[0];
            ctrl.en     <= wdata[1];
            ctrl.autold <= wdata[2];
            ctrl.flag   <= wdata[3] & ctrl.flag;
         end else if (expire) begin
            ctrl.flag   <= 1'b1;
         end
         if (wr_period) period <= wdata;
         if (wr_scale)  scale  <= wdata;
      end
   end

   // R9: an expiry leaves the sticky flag set
   assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> ctrl.flag);

   // R9: a control write with bit 3 clear leaves the flag clear
   assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && !wdata[3]) |=> !ctrl.flag);

endmodule

// File: rtl/tdt_prescale.sv
module tdt_prescale #(
   parameter int DATA_W       = 32,
   parameter bit HAS_PRESCALE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              restart,
   input  logic [DATA_W-1:0] scale,
   output logic              tick
);

   generate
      if (HAS_PRESCALE) begin : g_div
         logic [DATA_W-1:0] div_q;
         logic              wrap;

         assign wrap = (div_q == scale);
         assign tick = active && wrap;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               div_q <= '0;
            end else if (restart || !active || wrap) begin
               div_q <= '0;
            end else begin
               div_q <= div_q + 1'b1;
            end
         end

         // R4: the divider never runs past the programmed scale
         assert_div_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
            div_q <= scale);
      end else begin : g_nodiv
         logic unused_pre;
         assign unused_pre = ^{scale, restart, clk, rst_n};
         assign tick       = active;
      end
   endgenerate

endmodule

// File: rtl/tdt_counter.sv
module tdt_counter #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              autold,
   input  logic              wr_ctrl,
   input  logic              wr_count,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] period,
   input  logic              tick,
   output logic [DATA_W-1:0] count,
   output logic              active,
   output logic              expire,
   output logic              irq
);

   logic done_q;
   logic at_zero;

   assign at_zero = (count == '0);
   assign active  = run && !done_q;
   assign expire  = active && at_zero && !wr_ctrl && !wr_count;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count  <= '0;
         done_q <= 1'b0;
         irq    <= 1'b0;
      end else begin
         irq <= expire;
         if (wr_count) begin
            count <= wdata;
         end else if (expire && autold) begin
            count <= period;
         end else if (active && !at_zero && tick) begin
            count <= count - 1'b1;
         end
         if (wr_ctrl || wr_count) begin
            done_q <= 1'b0;
         end else if (expire && !autold) begin
            done_q <= 1'b1;
         end
      end
   end

   // R3: no counting unless power and enable are both set
   assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_count) |=> $stable(count));

   // R4: the count only moves on a prescaler tick, a write or an expiry
   assert_no_step_without_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_count && !expire && !tick) |=> $stable(count));

   // R5: a one-shot expiry holds the count at zero
   assert_oneshot_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !autold) |-> at_zero);

   // R6: an auto-reload expiry loads the period of the expiry cycle
   assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && autold) |-> (count == $past(period)));

   // R10: a count write wins over any internal update
   assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_count |=> (count == $past(wdata)));

endmodule

// File: rtl/tick_down_timer.sv
module tick_down_timer
   import tdt_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int ADDR_W       = 4,
   parameter bit HAS_PRESCALE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_out
);

   localparam int PAD_W = DATA_W - CTRL_BITS;

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("tick_down_timer: DATA_W must be at least 8");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("tick_down_timer: ADDR_W must be at least 4");
      end
   endgenerate

   tdt_sel_e          sel;
   logic              wr_ctrl, wr_period, wr_scale, wr_count;
   tdt_ctrl_t         ctrl;
   logic [DATA_W-1:0] period, scale, count;
   logic              active, expire, tick, irq;
   logic              unused_addr;

   assign sel         = tdt_sel_e'(bus_addr[3:2]);
   assign unused_addr = ^{bus_addr[1:0], bus_addr[ADDR_W-1:2]};

   assign wr_ctrl   = bus_wr_en && (sel == SEL_CTRL);
   assign wr_period = bus_wr_en && (sel == SEL_PERIOD);
   assign wr_scale  = bus_wr_en && (sel == SEL_SCALE);
   assign wr_count  = bus_wr_en && (sel == SEL_COUNT);

   tdt_regs #(.DATA_W(DATA_W)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctrl   (wr_ctrl),
      .wr_period (wr_period),
      .wr_scale  (wr_scale),
      .wdata     (bus_wdata),
      .expire    (expire),
      .ctrl      (ctrl),
      .period    (period),
      .scale     (scale)
   );

   tdt_prescale #(.DATA_W(DATA_W), .HAS_PRESCALE(HAS_PRESCALE)) i_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (active),
      .restart (wr_scale || wr_count || expire),
      .scale   (scale),
      .tick    (tick)
   );

   tdt_counter #(.DATA_W(DATA_W)) i_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (ctrl.pwr && ctrl.en),
      .autold   (ctrl.autold),
      .wr_ctrl  (wr_ctrl),
      .wr_count (wr_count),
      .wdata    (bus_wdata),
      .period   (period),
      .tick     (tick),
      .count    (count),
      .active   (active),
      .expire   (expire),
      .irq      (irq)
   );

   always_comb begin
      unique case (sel)
         SEL_CTRL:   bus_rdata = {{PAD_W{1'b0}}, ctrl};
         SEL_PERIOD: bus_rdata = period;
         SEL_SCALE:  bus_rdata = scale;
         default:    bus_rdata = count;
      endcase
   end

   assign irq_out = irq;

   // R8: the request never appears without the sticky flag
   assert_irq_has_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> ctrl.flag);

   // R5: a one-shot expiry keeps power and enable set
   assert_oneshot_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out && !ctrl.autold) |-> (ctrl.pwr && ctrl.en));

endmodule

// File: tb/test_tick_down_timer.sv
module test_tick_down_timer;

   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [3:0]    addr = 4'h0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          irq;

   int n_checks = 0;
   int n_fails  = 0;
   int n_irq    = 0;
   int cycles   = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   tick_down_timer i_tick_down_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr_en (wr_en),
      .bus_addr  (addr),
      .bus_wdata (wdata),
      .bus_rdata (rdata),
      .irq_out   (irq)
   );

   // reference model built from the requirements
   bit          m_pwr, m_en, m_auto, m_flag, m_done, m_irq;
   logic [DW-1:0] m_per, m_scl, m_cnt, m_div;

   function automatic logic [DW-1:0] m_read(input logic [1:0] s);
      case (s)
         2'd0:    return {28'd0, m_flag, m_auto, m_en, m_pwr};
         2'd1:    return m_per;
         2'd2:    return m_scl;
         default: return m_cnt;
      endcase
   endfunction

   always @(posedge clk) begin
      bit wc, wn, act, exp_ev, tk;
      cycles <= cycles + 1;
      if (!rst_n) begin
         m_pwr <= 0; m_en <= 0; m_auto <= 0; m_flag <= 0; m_done <= 0; m_irq <= 0;
         m_per <= '0; m_scl <= '0; m_cnt <= '0; m_div <= '0;
      end else begin
         wc     = wr_en && addr[3:2] == 2'd0;
         wn     = wr_en && addr[3:2] == 2'd3;
         act    = m_pwr && m_en && !m_done;
         exp_ev = act && m_cnt == 0 && !wc && !wn;
         tk     = act && m_div == m_scl;
         m_irq <= exp_ev;
         if (exp_ev) n_irq <= n_irq + 1;
         if (wr_en && (addr[3:2] == 2'd2 || addr[3:2] == 2'd3)) m_div <= '0;
         else if (!act || exp_ev || m_div == m_scl) m_div <= '0;
         else m_div <= m_div + 1;
         if (wn) m_cnt <= wdata;
         else if (exp_ev && m_auto) m_cnt <= m_per;
         else if (act && m_cnt != 0 && tk) m_cnt <= m_cnt - 1;
         if (wc || wn) m_done <= 0;
         else if (exp_ev && !m_auto) m_done <= 1;
         if (wc) begin
            m_pwr <= wdata[0]; m_en <= wdata[1]; m_auto <= wdata[2];
            m_flag <= wdata[3] & m_flag;
         end else if (exp_ev) m_flag <= 1;
         if (wr_en && addr[3:2] == 2'd1) m_per <= wdata;
         if (wr_en && addr[3:2] == 2'd2) m_scl <= wdata;
      end
   end

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp_v);
      n_checks++;
      if (act !== exp_v) begin
         n_fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, act, exp_v, cycles);
      end
   endtask

   function automatic string tag_of(input logic [1:0] s);
      case (s)
         2'd0:    return "R3";
         2'd3:    return "R4";
         default: return "R2";
      endcase
   endfunction

   // drive one cycle at the falling edge, then compare at the next falling edge
   task automatic step(input bit we, input logic [1:0] s, input logic [DW-1:0] d);
      wr_en = we; addr = {s, 2'b00}; wdata = d;
      @(negedge clk);
      check(tag_of(s), rdata, m_read(s));
      check("R8", {31'd0, irq}, {31'd0, m_irq});
   endtask

   task automatic wr(input logic [1:0] s, input logic [DW-1:0] d);
      step(1'b1, s, d);
   endtask

   task automatic rd(input logic [1:0] s);
      step(1'b0, s, '0);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) rd(2'd3);
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fails++;
         n_checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

   initial begin : main
      int irq0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values
      for (int s = 0; s < 4; s++) begin
         rd(2'(s));
         check("R1", rdata, 32'd0);
      end
      check("R1", {31'd0, irq}, 32'd0);

      // R2 / R3: register map, timer off keeps count
      wr(2'd1, 32'h50);
      wr(2'd2, 32'd0);
      wr(2'd3, 32'd3);
      wr(2'd0, 32'h1);
      idle(5);
      check("R3", rdata, 32'd3);
      rd(2'd1); check("R2", rdata, 32'h50);

      // R5: one-shot run to zero
      irq0 = n_irq;
      wr(2'd0, 32'h3);
      idle(20);
      rd(2'd0); check("R5", rdata, 32'hB);
      rd(2'd3); check("R5", rdata, 32'd0);
      check("R5", n_irq - irq0, 1);
      rd(2'd1); check("R2", rdata, 32'h50);

      // R9: flag kept by bit 3 set, cleared by bit 3 clear
      wr(2'd0, 32'h9); check("R9", rdata, 32'h9);
      wr(2'd0, 32'h1); check("R9", rdata, 32'h1);

      // R7: enabling at count zero expires at once
      wr(2'd0, 32'h3);
      check("R7", {31'd0, irq}, 32'd0);
      rd(2'd0);
      check("R7", {31'd0, irq}, 32'd1);
      rd(2'd0);
      check("R8", {31'd0, irq}, 32'd0);

      // R6: auto-reload with prescale 2
      wr(2'd0, 32'h0);
      wr(2'd1, 32'h4);
      wr(2'd3, 32'd2);
      wr(2'd2, 32'd2);
      irq0 = n_irq;
      wr(2'd0, 32'h7);
      idle(6);
      check("R4", rdata, 32'd0);
      idle(40);
      rd(2'd0); check("R6", rdata, 32'hF);
      check("R6", (n_irq - irq0) >= 2, 1);
      rd(2'd1); check("R2", rdata, 32'h4);

      // R10: count write in the would-be expiry cycle
      wr(2'd0, 32'h0);
      wr(2'd3, 32'd0);
      wr(2'd0, 32'h3);
      wr(2'd3, 32'd7);
      check("R10", rdata, 32'd7);
      check("R10", {31'd0, irq}, 32'd0);
      wr(2'd3, 32'd9);
      check("R10", rdata, 32'd9);

      // constrained random phase against the model
      void'($urandom(32'd20240611));
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = int'($urandom_range(0, 15));
         if (r < 2) begin
            logic [1:0] s;
            logic [DW-1:0] d;
            s = 2'($urandom_range(0, 3));
            case (s)
               2'd0: d = 32'($urandom_range(0, 15) | (($urandom_range(0, 3) != 0) ? 3 : 0));
               2'd1: d = 32'($urandom_range(0, 15));
               2'd2: d = 32'($urandom_range(0, 3));
               default: d = 32'($urandom_range(0, 20));
            endcase
            wr(s, d);
         end else begin
            rd(2'($urandom_range(0, 3)));
         end
      end

      wr(2'd0, 32'h0);
      check("R3", rdata, 32'd0);
      finished = 1'b1;
      summary();
   end

endmodule